// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block forms the product of two 32-bit binary floating-point values in the standard single-precision layout: 1 sign bit, an 8-bit biased exponent with bias 127, and a 23-bit fraction. For two normal operands it restores the hidden leading one on each fraction and multiplies the two 24-bit significands as unsigned integers. It sums the biased exponents and removes the bias once. The significand product lies in [1, 4), so a single right shift normalizes it. The block then rounds the result under one of four selectable modes and checks the final exponent against the representable range.

The multiplier is a two-stage pipeline. An operation is presented with a one-cycle `in_valid` strobe, a new one may follow on every cycle, and each result appears with `out_valid` exactly two clock edges after its operands were sampled. Operands with a zero exponent field, which covers zeros and subnormals, are treated as signed zero. Results too small for a normal number are flushed to signed zero. Four sticky-free status flags come with each result.

Top module: `fp32_mul`

## Requirements
- R1: For two normal operands whose product is in range, the result sign is the XOR of the operand signs, the biased exponent is Ea + Eb - 127, and the fraction comes from the product of the two significands with their hidden ones (e.g. 0x3FC00000 x 0x40000000 = 0x40400000).
- R2: When the significand product is 2.0 or more, it is shifted right by one bit and the exponent is incremented (e.g. 0x3FC00000 x 0x3FC00000 = 0x40100000).
- R3: `rnd_mode` selects rounding: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward minus infinity, 2'b11 toward plus infinity. The decision uses the first discarded bit (guard) and the OR of all lower bits (sticky). A rounding carry out of the fraction increments the exponent.
- R4: If the biased exponent after rounding is 255 or more, the result is infinity for nearest-even, for toward-plus on a positive result and for toward-minus on a negative result. Otherwise it is the largest finite value of that sign (0x7F7FFFFF magnitude). The overflow and inexact flags are set.
- R5: If the biased exponent after rounding is 0 or less, the result is zero carrying the product sign, and the underflow and inexact flags are set.
- R6: If either operand is a NaN (exponent field 255, fraction non-zero), the result is the quiet NaN 0x7FC00000 with no flag set, whatever the other operand is.
- R7: Infinity times a zero-class operand (exponent field 0) yields 0x7FC00000 with the invalid flag set.
- R8: Infinity times a normal operand or another infinity yields infinity whose sign is the XOR of the operand signs, with no flags.
- R9: A zero-class operand times a normal operand or a zero yields zero carrying the XOR sign, with no flags.
- R10: `flags` is {invalid, overflow, underflow, inexact} from bit 3 down to bit 0. Inexact is set exactly when a normal-path result differs from the exact product.
- R11: `out_valid` is high in the cycle two clock edges after an `in_valid` sample and at no other time, and one operation can be accepted on every cycle.
- R12: While `rst_n` is low at a clock edge, `out_valid`, `result` and `flags` are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are sampled this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | Rounding mode select |
| out_valid | output | 1 | `result` and `flags` hold a new product |
| result | output | 32 | Rounded product |
| flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
Hand-worked directed products separate the plain exponent path from the one-bit normalization shift. Products built to land a guard bit with and without sticky bits, on odd and on even fraction LSBs, tell each rounding mode apart from the others and expose the rounding carry into the exponent. Operands at the top and bottom of the exponent range distinguish the exact boundary values from overflow and flush-to-zero under each mode and sign. The special-value cases check the priority of NaN over infinity times zero, over infinity, over zero. A back-to-back stream of normal-range and unconstrained random operands, checked against a model computed in the bench, exercises full throughput and the fixed latency.

// File: rtl/fp32_mul_pkg.sv
// Shared constants and types for the floating-point multiplier.
// Assumes the single-precision layout; all widths derive from EXP_W/FRAC_W.
package fp32_mul_pkg;
    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;

    // Rounding mode encoding seen on the rnd_mode port.
    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_ZERO   = 2'b01,
        RND_DOWN      = 2'b10,
        RND_UP        = 2'b11
    } rnd_mode_e;

    // Classification of the operand pair, in priority order.
    typedef struct packed {
        logic nan;    // any NaN operand
        logic inv;    // infinity times zero
        logic inf;    // infinite result
        logic zero;   // zero result
    } spec_t;

    // Bit positions inside the flags output.
    localparam int FLG_NX = 0;
    localparam int FLG_UF = 1;
    localparam int FLG_OF = 2;
    localparam int FLG_NV = 3;
    localparam int FLG_W  = 4;
endpackage

// File: rtl/fp32_mul_unpack.sv
// Splits one operand into sign, exponent and significand and classifies it.
// Assumes an exponent field of zero means zero (subnormals are read as zero).
module fp32_mul_unpack #(
    parameter int EXP_W  = fp32_mul_pkg::EXP_W,
    parameter int FRAC_W = fp32_mul_pkg::FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]      op,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [FRAC_W:0]   sig,
    output logic              is_nan,
    output logic              is_inf,
    output logic              is_zero
);
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;

    // Field extraction and class decode.
    always_comb begin
        sign     = op[W-1];
        expo     = op[W-2 -: EXP_W];
        frac     = op[FRAC_W-1:0];
        exp_ones = &expo;
        is_zero  = (expo == '0);
        is_nan   = exp_ones && (frac != '0);
        is_inf   = exp_ones && (frac == '0);
        sig      = {~is_zero, frac};
    end
endmodule

// File: rtl/fp32_mul_round.sv
// Normalizes the raw significand product, rounds it, checks the exponent
// range and packs the final word with its flags. Purely combinational.
// Assumes exp_base already holds Ea + Eb - bias as a two's-complement value.
module fp32_mul_round
    import fp32_mul_pkg::*;
#(
    parameter int EXP_W  = fp32_mul_pkg::EXP_W,
    parameter int FRAC_W = fp32_mul_pkg::FRAC_W,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int XW     = EXP_W + 2
) (
    input  logic              sign,
    input  logic [XW-1:0]     exp_base,
    input  logic [PROD_W-1:0] prod,
    input  logic [1:0]        rnd,
    input  spec_t             spec,
    output logic [W-1:0]      result,
    output logic [FLG_W-1:0]  flags
);
    localparam int G_POS = PROD_W - 2 - FRAC_W;
    localparam logic [EXP_W-1:0] EXP_ALL = '1;
    localparam logic signed [XW-1:0] EXP_LIMIT = XW'((1 << EXP_W) - 1);

    logic              hi;
    logic [PROD_W-1:0] norm;
    logic [FRAC_W-1:0] frac_n;
    logic              guard, sticky, lsb, inc, carry;
    logic [FRAC_W:0]   sum;
    logic [XW-1:0]     exp_n, exp_r;
    logic              big, tiny, to_inf;

    // Normalization: product in [1,4) needs at most one right shift.
    always_comb begin
        hi     = prod[PROD_W-1];
        norm   = hi ? prod : (prod << 1);
        frac_n = norm[PROD_W-2 -: FRAC_W];
        guard  = norm[G_POS];
        sticky = |norm[G_POS-1:0];
        lsb    = frac_n[0];
        exp_n  = exp_base + XW'(hi);
    end

    // Rounding decision per mode, with carry back into the exponent.
    always_comb begin
        unique case (rnd_mode_e'(rnd))
            RND_NEAR_EVEN: inc = guard & (sticky | lsb);
            RND_TO_ZERO:   inc = 1'b0;
            RND_DOWN:      inc = sign & (guard | sticky);
            default:       inc = ~sign & (guard | sticky);
        endcase
        sum   = {1'b0, frac_n} + {{FRAC_W{1'b0}}, inc};
        carry = sum[FRAC_W];
        exp_r = exp_n + XW'(carry);
    end

    // Range check and choice of the overflow value.
    always_comb begin
        big    = $signed(exp_r) >= EXP_LIMIT;
        tiny   = $signed(exp_r) <= $signed(XW'(0));
        to_inf = (rnd_mode_e'(rnd) == RND_NEAR_EVEN) ||
                 (rnd_mode_e'(rnd) == RND_UP   && !sign) ||
                 (rnd_mode_e'(rnd) == RND_DOWN &&  sign);
    end

    // Final packing: special classes first, then the normal path.
    always_comb begin
        flags = '0;
        if (spec.nan) begin
            result = {1'b0, EXP_ALL, 1'b1, {(FRAC_W-1){1'b0}}};
        end else if (spec.inv) begin
            result = {1'b0, EXP_ALL, 1'b1, {(FRAC_W-1){1'b0}}};
            flags[FLG_NV] = 1'b1;
        end else if (spec.inf) begin
            result = {sign, EXP_ALL, {FRAC_W{1'b0}}};
        end else if (spec.zero) begin
            result = {sign, {(W-1){1'b0}}};
        end else if (big) begin
            result = to_inf ? {sign, EXP_ALL, {FRAC_W{1'b0}}}
                            : {sign, EXP_ALL - EXP_W'(1), {FRAC_W{1'b1}}};
            flags[FLG_OF] = 1'b1;
            flags[FLG_NX] = 1'b1;
        end else if (tiny) begin
            result = {sign, {(W-1){1'b0}}};
            flags[FLG_UF] = 1'b1;
            flags[FLG_NX] = 1'b1;
        end else begin
            result = {sign, exp_r[EXP_W-1:0], sum[FRAC_W-1:0]};
            flags[FLG_NX] = guard | sticky;
        end
    end
endmodule

// File: rtl/fp32_mul.sv
// Two-stage floating-point multiplier. Stage 1 unpacks, classifies,
// multiplies significands and forms Ea + Eb - bias; stage 2 normalizes,
// rounds and packs. Accepts one operation per cycle; latency two edges.
// Assumes synchronous active-low reset and flush-to-zero on both sides.
module fp32_mul
    import fp32_mul_pkg::*;
#(
    parameter int EXP_W  = fp32_mul_pkg::EXP_W,
    parameter int FRAC_W = fp32_mul_pkg::FRAC_W,
    localparam int W      = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int XW     = EXP_W + 2,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [1:0]       rnd_mode,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic [FLG_W-1:0] flags
);
    logic [1:0][W-1:0]      ops;
    logic [1:0]             u_sign, u_nan, u_inf, u_zero;
    logic [1:0][EXP_W-1:0]  u_exp;
    logic [1:0][SIG_W-1:0]  u_sig;

    assign ops = {op_b, op_a};

    // One unpacker per operand.
    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fp32_mul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_unpack (
            .op      (ops[gi]),
            .sign    (u_sign[gi]),
            .expo    (u_exp[gi]),
            .sig     (u_sig[gi]),
            .is_nan  (u_nan[gi]),
            .is_inf  (u_inf[gi]),
            .is_zero (u_zero[gi])
        );
    end

    spec_t             spec_c;
    logic [PROD_W-1:0] prod_c;
    logic [XW-1:0]     exp_c;

    // Stage-1 datapath: classification, significand product, exponent sum.
    always_comb begin
        spec_c.nan  = |u_nan;
        spec_c.inv  = (u_inf[0] & u_zero[1]) | (u_inf[1] & u_zero[0]);
        spec_c.inf  = |u_inf;
        spec_c.zero = |u_zero;
        prod_c      = PROD_W'(u_sig[0]) * PROD_W'(u_sig[1]);
        exp_c       = XW'(u_exp[0]) + XW'(u_exp[1]) - XW'(BIAS);
    end

    logic              s1_valid, s1_sign;
    logic [XW-1:0]     s1_exp;
    logic [PROD_W-1:0] s1_prod;
    logic [1:0]        s1_rnd;
    spec_t             s1_spec;

    // Stage-1 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_exp   <= '0;
            s1_prod  <= '0;
            s1_rnd   <= '0;
            s1_spec  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= ^u_sign;
            s1_exp   <= exp_c;
            s1_prod  <= prod_c;
            s1_rnd   <= rnd_mode;
            s1_spec  <= spec_c;
        end
    end

    logic [W-1:0]     res_c;
    logic [FLG_W-1:0] flg_c;

    fp32_mul_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_round (
        .sign     (s1_sign),
        .exp_base (s1_exp),
        .prod     (s1_prod),
        .rnd      (s1_rnd),
        .spec     (s1_spec),
        .result   (res_c),
        .flags    (flg_c)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags     <= '0;
        end else begin
            out_valid <= s1_valid;
            result    <= res_c;
            flags     <= flg_c;
        end
    end
endmodule

// File: rtl/fp32_mul_chk.sv
// Property checker for fp32_mul, attached through bind.
// Assumes the flag layout and rounding encoding of fp32_mul_pkg.
module fp32_mul_chk
    import fp32_mul_pkg::*;
#(
    parameter int EXP_W  = fp32_mul_pkg::EXP_W,
    parameter int FRAC_W = fp32_mul_pkg::FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     op_a,
    input logic [W-1:0]     op_b,
    input logic             out_valid,
    input logic [W-1:0]     result,
    input logic [FLG_W-1:0] flags
);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [EXP_W-1:0] EXP_NEAR_TOP = {{(EXP_W-1){1'b1}}, 1'b0};

    logic [1:0] run_cnt;

    // Edges since reset release, saturating, to guard two-cycle lookbacks.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_cnt <= '0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    p_reset_clear_r12: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && flags == '0));

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_sign_xor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2 && out_valid && result != QNAN)
        |-> (result[W-1] == $past(op_a[W-1] ^ op_b[W-1], 2)));

    p_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[FLG_OF])
        |-> (flags[FLG_NX] && result[W-2 -: EXP_W] >= EXP_NEAR_TOP && !flags[FLG_UF]));

    p_underflow_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[FLG_UF]) |-> (flags[FLG_NX] && result[W-2:0] == '0));

    p_invalid_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags[FLG_NV]) |-> (result == QNAN && $countones(flags) == 1));

    p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result == QNAN) |-> (flags[FLG_NX] == 1'b0));
endmodule

bind fp32_mul fp32_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/test_fp32_mul.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected words, the monitor compares.
module test_fp32_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  rnd_mode = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [3:0]  flags;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 1'b0;

    logic [35:0] exp_q[$];
    string       tag_q[$];
    int          cyc_q[$];

    localparam logic [31:0] QNAN = 32'h7FC00000;

    fp32_mul i_fp32_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .result(result), .flags(flags)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Bench model built from the requirements (flags in [35:32]).
    function automatic logic [35:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                             input logic [1:0] m);
        logic s, an, bn, ai, bi, az, bz, g, st, inc;
        int ea, eb, e;
        logic [47:0] p;
        logic [22:0] fr;
        logic [23:0] sum;
        logic [31:0] r;
        logic [3:0]  f;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        an = (ea == 255) && (a[22:0] != 0);
        bn = (eb == 255) && (b[22:0] != 0);
        ai = (ea == 255) && (a[22:0] == 0);
        bi = (eb == 255) && (b[22:0] == 0);
        az = (ea == 0);
        bz = (eb == 0);
        f  = 4'b0000;
        if (an || bn) r = QNAN;
        else if ((ai && bz) || (bi && az)) begin r = QNAN; f = 4'b1000; end
        else if (ai || bi) r = {s, 8'hFF, 23'h0};
        else if (az || bz) r = {s, 31'h0};
        else begin
            p = {1'b1, a[22:0]} * {1'b1, b[22:0]};
            e = ea + eb - 127;
            if (p[47]) e++;
            else p = p << 1;
            fr = p[46:24];
            g  = p[23];
            st = |p[22:0];
            case (m)
                2'd0:    inc = g & (st | fr[0]);
                2'd1:    inc = 1'b0;
                2'd2:    inc = s & (g | st);
                default: inc = !s & (g | st);
            endcase
            sum = {1'b0, fr} + 24'(inc);
            if (sum[23]) e++;
            if (e >= 255) begin
                f = 4'b0101;
                r = (m == 2'd0 || (m == 2'd3 && !s) || (m == 2'd2 && s))
                    ? {s, 8'hFF, 23'h0} : {s, 8'hFE, 23'h7FFFFF};
            end else if (e <= 0) begin
                f = 4'b0011;
                r = {s, 31'h0};
            end else begin
                r = {s, 8'(e), sum[22:0]};
                f = {3'b000, g | st};
            end
        end
        return {f, r};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, want);
        end
    endtask

    // Driver: present one operation and queue its expected outcome.
    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                         input logic [35:0] want, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; op_a = a; op_b = b; rnd_mode = m;
        exp_q.push_back(want);
        tag_q.push_back(tag);
        cyc_q.push_back(cyc);
    endtask

    task automatic dm(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                      input logic [3:0] f, input logic [31:0] r, input string tag);
        drive(a, b, m, {f, r}, tag);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        in_valid = 1'b0; op_a = '0; op_b = '0;
        repeat (n) @(posedge clk);
    endtask

    // Monitor: compare each output with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected out_valid", 64'(1), 64'(0));
            end else begin
                logic [35:0] w;
                string t;
                int c0;
                w  = exp_q.pop_front();
                t  = tag_q.pop_front();
                c0 = cyc_q.pop_front();
                check(t, 64'({flags, result}), 64'(w));
                check({"R11 latency ", t}, 64'(cyc - c0), 64'(2));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 in_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
        repeat (2) @(posedge clk);
        #1;
        check("R12 reset out_valid", 64'(out_valid), 64'(0));
        check("R12 reset result", 64'({flags, result}), 64'(0));
        in_valid = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 / R2: exponent path and one-bit normalization.
        dm(32'h3FC00000, 32'h40000000, 2'd0, 4'h0, 32'h40400000, "R1 1.5*2");
        dm(32'hC0400000, 32'h40000000, 2'd0, 4'h0, 32'hC0C00000, "R1 -3*2 sign");
        dm(32'h3FC00000, 32'h3FC00000, 2'd0, 4'h0, 32'h40100000, "R2 1.5*1.5 shift");
        // R3 / R10: guard below half with sticky.
        dm(32'h3F800001, 32'h3F800001, 2'd0, 4'h1, 32'h3F800002, "R3 near sticky");
        dm(32'h3F800001, 32'h3F800001, 2'd3, 4'h1, 32'h3F800003, "R3 up sticky");
        dm(32'h3F800001, 32'h3F800001, 2'd1, 4'h1, 32'h3F800002, "R3 zero sticky");
        dm(32'hBF800001, 32'h3F800001, 2'd2, 4'h1, 32'hBF800003, "R3 down neg");
        dm(32'hBF800001, 32'h3F800001, 2'd3, 4'h1, 32'hBF800002, "R3 up neg");
        // R3: exact ties.
        dm(32'h3F800001, 32'h3FC00000, 2'd0, 4'h1, 32'h3FC00002, "R3 tie odd");
        dm(32'h3F800001, 32'h3FC00000, 2'd1, 4'h1, 32'h3FC00001, "R3 tie trunc");
        dm(32'h3F800003, 32'h3FC00000, 2'd0, 4'h1, 32'h3FC00004, "R3 tie even");
        dm(32'h3F800003, 32'h3FC00000, 2'd3, 4'h1, 32'h3FC00005, "R3 tie up");
        // R3: rounding carry into the exponent.
        dm(32'h3FFFFFFE, 32'h3F800001, 2'd0, 4'h1, 32'h40000000, "R3 round carry");
        dm(32'h3FFFFFFE, 32'h3F800001, 2'd1, 4'h1, 32'h3FFFFFFF, "R3 no carry trunc");
        // R4: top of range.
        dm(32'h7F000000, 32'h3FFFFFFF, 2'd0, 4'h0, 32'h7F7FFFFF, "R10 max exact");
        dm(32'h7F000000, 32'h40000000, 2'd0, 4'h5, 32'h7F800000, "R4 ovf near");
        dm(32'h7F000000, 32'h40000000, 2'd1, 4'h5, 32'h7F7FFFFF, "R4 ovf trunc");
        dm(32'hFF000000, 32'h40000000, 2'd3, 4'h5, 32'hFF7FFFFF, "R4 ovf up neg");
        dm(32'hFF000000, 32'h40000000, 2'd2, 4'h5, 32'hFF800000, "R4 ovf down neg");
        dm(32'h7F000000, 32'h40000000, 2'd2, 4'h5, 32'h7F7FFFFF, "R4 ovf down pos");
        // R5: bottom of range.
        dm(32'h00800000, 32'h3F800000, 2'd0, 4'h0, 32'h00800000, "R5 min normal");
        dm(32'h00800000, 32'h3F000000, 2'd0, 4'h3, 32'h00000000, "R5 flush pos");
        dm(32'h80800000, 32'h3F000000, 2'd3, 4'h3, 32'h80000000, "R5 flush neg");
        // R6 .. R9: special classes and their priority.
        dm(32'h7FC00001, 32'h3F800000, 2'd0, 4'h0, QNAN, "R6 nan a");
        dm(32'h3F800000, 32'hFF800001, 2'd0, 4'h0, QNAN, "R6 nan b");
        dm(32'h7FC00000, 32'h00000000, 2'd0, 4'h0, QNAN, "R6 nan times zero");
        dm(32'h7F800000, 32'h00000000, 2'd0, 4'h8, QNAN, "R7 inf*0");
        dm(32'h80000000, 32'hFF800000, 2'd0, 4'h8, QNAN, "R7 0*-inf");
        dm(32'h7F800000, 32'h00000001, 2'd0, 4'h8, QNAN, "R7 inf*sub");
        dm(32'hFF800000, 32'h40000000, 2'd0, 4'h0, 32'hFF800000, "R8 -inf*2");
        dm(32'h7F800000, 32'hFF800000, 2'd0, 4'h0, 32'hFF800000, "R8 inf*-inf");
        dm(32'h80000000, 32'h40400000, 2'd0, 4'h0, 32'h80000000, "R9 -0*3");
        dm(32'h00000001, 32'h3F800000, 2'd0, 4'h0, 32'h00000000, "R9 sub*1");
        dm(32'h7F7FFFFF, 32'h80000000, 2'd0, 4'h0, 32'h80000000, "R9 max*-0");
        idle(3);

        // R1 / R3 / R11: back-to-back normal-range stream.
        for (int i = 0; i < 200; i++) begin
            logic [31:0] a, b;
            logic [1:0]  m;
            a = {1'($urandom), 8'(64 + $urandom_range(0, 126)), 23'($urandom)};
            b = {1'($urandom), 8'(64 + $urandom_range(0, 126)), 23'($urandom)};
            m = 2'(i);
            drive(a, b, m, ref_mul(a, b, m), "R1 R3 stream");
        end
        // R4 .. R9: unconstrained operands, with gaps.
        for (int i = 0; i < 200; i++) begin
            logic [31:0] a, b;
            logic [1:0]  m;
            a = $urandom;
            b = $urandom;
            m = 2'($urandom);
            drive(a, b, m, ref_mul(a, b, m), "R10 random");
            if (i % 7 == 0) idle(1);
        end
        idle(5);
        check("R11 all results returned", 64'(exp_q.size()), 64'(0));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule